// File: doc/BRIEF.md
# Cascadable Priority Request Encoder

This block turns a set of request lines into the binary index of the most important request that is currently raised. Each encoding stage serves eight lanes. Inside the stage, the first step marks the single highest raised lane as a one-hot vector. The index bits are then taken from that vector, so a lower request never leaks into the code. A stage also reports whether anything is requesting, and it raises a pass-down flag when it is enabled and idle. The pass-down flag enables the next, lower-ranked stage, so stages can be chained.

The top module joins two stages into a sixteen-lane encoder. The upper stage handles lanes 15..8 and takes the external enable. The lower stage handles lanes 7..0 and is enabled only by the upper stage's pass-down flag. The upper stage's activity flag becomes the top bit of the four-bit code. The three lower code bits are the OR of the two stage codes. A polarity parameter chooses whether every pin (requests, enable, code, activity and pass-down) is asserted low or high. The block is purely combinational.

Top module: `prio_enc_cascade`

## Requirements
- R1: When enabled with at least one request raised, the 4-bit code equals the number of the highest raised lane (0..15). Lane 15 has the highest rank.
- R2: Lanes ranked below the highest raised lane have no effect. With only lanes 2 and 4 raised, the code is 4 and never 6.
- R3: Inside each stage, code bit b is the OR of the one-hot highest-lane flags whose lane index has bit b set. At most one flag is set at any time.
- R4: The activity output is asserted when enabled and any of the sixteen lanes is raised.
- R5: The pass-down output is asserted exactly when enabled and no lane is raised. It is never asserted together with the activity output.
- R6: When the enable is deasserted, the code, activity and pass-down outputs all take their inactive values, whatever the requests.
- R7: With POL = POL_LOW, every pin is asserted at 0, and each code bit appears inverted (code 4 reads 4'b1011). With POL = POL_HIGH, every pin is asserted at 1.
- R8: Code bit 3 is set exactly when one of lanes 15..8 is raised. The lower stage is enabled only through the upper stage's pass-down flag, so lanes 7..0 are ignored while any upper lane is raised. At most one stage ever produces a nonzero code.
- R9: When enabled with no lane raised, the code is 0 and the activity output is deasserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | 16 | Request lanes, pin polarity set by POL |
| en_i | input | 1 | Enable, pin polarity set by POL |
| code_o | output | 4 | Index of highest raised lane, pin polarity set by POL |
| gs_o | output | 1 | Some lane raised while enabled |
| eo_o | output | 1 | Enabled and idle; feeds a lower-ranked encoder |

## Verification
The hardest situations to reach are those where a raised lower lane must stay hidden. One case is a lower-half lane raised alongside an upper-half lane, where the lower stage has to stay disabled through the chained enable. The other is a pair of lanes whose plain OR of indices would give a wrong code. The stimulus walks all 65536 request patterns with the enable asserted, so every such masking pair occurs. It drives both polarity variants side by side against a highest-set-bit model. Dedicated patterns then cover the case with lanes 2 and 4, cross-half pairs, and a disabled sweep with requests present.

// File: rtl/prio_pkg.sv
package prio_pkg;

    // Pin polarity selection shared by every module of the encoder
    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pin_pol_e;

    // Width of a lane index for a stage of n lanes
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prio_pin_adapt.sv
// Converts between pin polarity and internal active-high logic.
// The mapping is its own inverse, so one module serves inputs and outputs.
module prio_pin_adapt #(
    parameter prio_pkg::pin_pol_e POL = prio_pkg::POL_LOW,
    parameter int unsigned        W   = 1
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_o
);
    generate
        if (POL == prio_pkg::POL_LOW) begin : g_invert
            assign y_o = ~a_i;
        end else begin : g_pass
            assign y_o = a_i;
        end
    endgenerate
endmodule

// File: rtl/prio_onehot.sv
// Marks the single highest raised lane of an enabled stage.
module prio_onehot #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] req_i,
    input  logic         en_i,
    output logic [N-1:0] hot_o
);
    // above_d[i] is set when any lane at index i or higher is raised
    logic [N:0] above_d;

    assign above_d[N] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_lane
            assign above_d[i] = above_d[i+1] | req_i[i];
            assign hot_o[i]   = en_i & req_i[i] & ~above_d[i+1];
        end
    endgenerate

    always_comb begin
        AST_HOT_ONEHOT: assert ($onehot0(hot_o)) else $error("two highest flags"); // R3
        AST_HOT_NEEDS_REQ: assert ((hot_o & ~req_i) == '0) else $error("flag without request"); // R2
        AST_HOT_PRESENT: assert (!(en_i && (req_i != '0)) || (hot_o != '0)) else $error("request lost"); // R1
    end
endmodule

// File: rtl/prio_stage.sv
// One chainable encoding stage: one-hot highest lane, binary code,
// activity and pass-down flags, all active high internally.
module prio_stage #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]                          req_i,
    input  logic                                  en_i,
    output logic [prio_pkg::idx_width(N)-1:0]     code_o,
    output logic                                  gs_o,
    output logic                                  eo_o
);
    localparam int unsigned CW = prio_pkg::idx_width(N);

    logic [N-1:0]  hot_d;
    logic [CW-1:0] code_d;
    logic          any_d;

    prio_onehot #(.N(N)) u_hot (
        .req_i (req_i),
        .en_i  (en_i),
        .hot_o (hot_d)
    );

    // Each code bit gathers the flags whose index carries that bit
    generate
        for (genvar b = 0; b < CW; b++) begin : g_bit
            logic [N-1:0] sel_d;
            for (genvar i = 0; i < N; i++) begin : g_sel
                assign sel_d[i] = (((i >> b) & 1) == 1) ? hot_d[i] : 1'b0;
            end
            assign code_d[b] = |sel_d;
        end
    endgenerate

    assign any_d  = |req_i;
    assign code_o = code_d;
    assign gs_o   = en_i & any_d;
    assign eo_o   = en_i & ~any_d;

    always_comb begin
        AST_GS_EO_EXCL: assert (!(gs_o && eo_o)) else $error("busy and idle"); // R5
        AST_OFF_QUIET: assert (en_i || (code_o == '0 && !gs_o && !eo_o)) else $error("disabled stage active"); // R6
        AST_GS_FOLLOWS_HOT: assert (gs_o == (hot_d != '0)) else $error("activity mismatch"); // R4
    end
endmodule

// File: rtl/prio_enc_cascade.sv
// Sixteen-lane encoder built from two chained stages.
module prio_enc_cascade #(
    parameter prio_pkg::pin_pol_e POL   = prio_pkg::POL_LOW,
    parameter int unsigned        LANES = 8
) (
    input  logic [2*LANES-1:0]                    req_i,
    input  logic                                  en_i,
    output logic [prio_pkg::idx_width(LANES):0]   code_o,
    output logic                                  gs_o,
    output logic                                  eo_o
);
    localparam int unsigned CW = prio_pkg::idx_width(LANES);
    localparam int unsigned TW = 2 * LANES;

    logic [TW-1:0] req_d;
    logic          en_d;
    logic [CW-1:0] code_hi_d, code_lo_d;
    logic          gs_hi_d, gs_lo_d, eo_hi_d, eo_lo_d;
    logic [CW:0]   code_d;
    logic          gs_d, eo_d;

    prio_pin_adapt #(.POL(POL), .W(TW)) u_in_req (.a_i(req_i), .y_o(req_d));
    prio_pin_adapt #(.POL(POL), .W(1))  u_in_en  (.a_i(en_i),  .y_o(en_d));

    prio_stage #(.N(LANES)) u_hi (
        .req_i  (req_d[TW-1:LANES]),
        .en_i   (en_d),
        .code_o (code_hi_d),
        .gs_o   (gs_hi_d),
        .eo_o   (eo_hi_d)
    );

    // Lower stage is enabled only by the upper stage's pass-down flag
    prio_stage #(.N(LANES)) u_lo (
        .req_i  (req_d[LANES-1:0]),
        .en_i   (eo_hi_d),
        .code_o (code_lo_d),
        .gs_o   (gs_lo_d),
        .eo_o   (eo_lo_d)
    );

    always_comb begin
        code_d = {gs_hi_d, code_hi_d | code_lo_d};
        gs_d   = gs_hi_d | gs_lo_d;
        eo_d   = eo_lo_d;
    end

    prio_pin_adapt #(.POL(POL), .W(CW+1)) u_out_code (.a_i(code_d), .y_o(code_o));
    prio_pin_adapt #(.POL(POL), .W(1))    u_out_gs   (.a_i(gs_d),   .y_o(gs_o));
    prio_pin_adapt #(.POL(POL), .W(1))    u_out_eo   (.a_i(eo_d),   .y_o(eo_o));

    always_comb begin
        AST_ONE_STAGE_CODE: assert (!((code_hi_d != '0) && (code_lo_d != '0))) else $error("both stages coded"); // R8
        AST_LO_HIDDEN: assert (!gs_hi_d || !gs_lo_d) else $error("lower stage active under upper"); // R8
        AST_TOP_EXCL: assert (!(gs_d && eo_d)) else $error("top busy and idle"); // R5
    end
endmodule

// File: tb/sim_prio_enc_cascade.sv
module sim_prio_enc_cascade;
    logic clk = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    logic [15:0] req_l, req_h;
    logic        en_l, en_h;
    logic [3:0]  code_l, code_h;
    logic        gs_l, gs_h, eo_l, eo_h;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    prio_enc_cascade #(.POL(prio_pkg::POL_LOW), .LANES(8)) u0 (
        .req_i(req_l), .en_i(en_l), .code_o(code_l), .gs_o(gs_l), .eo_o(eo_l));
    prio_enc_cascade #(.POL(prio_pkg::POL_HIGH), .LANES(8)) u1 (
        .req_i(req_h), .en_i(en_h), .code_o(code_h), .gs_o(gs_h), .eo_o(eo_h));

    // Behavioural model: {code, gs, eo} in active-high terms
    function automatic logic [5:0] model(input logic [15:0] r, input logic en);
        int top = -1;
        for (int k = 0; k < 16; k++) if (r[k]) top = k;
        if (!en)       return 6'b0000_00;
        if (top < 0)   return 6'b0000_01;
        return {top[3:0], 2'b10};
    endfunction

    task automatic apply(input logic [15:0] r, input logic en);
        @(negedge clk);
        req_h = r;  en_h = en;
        req_l = ~r; en_l = ~en;
        #1;
    endtask

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_both(input string tag, input logic [15:0] r, input logic en);
        logic [5:0] e;
        e = model(r, en);
        check({tag, " high"}, {code_h, gs_h, eo_h}, e);
        check({tag, " low"},  {code_l, gs_l, eo_l}, ~e);
    endtask

    initial begin
        req_l = '1; en_l = 1'b1; req_h = '0; en_h = 1'b0;
        repeat (3) @(posedge clk);

        // Idle state, R9 and R5
        apply(16'h0000, 1'b1);
        check("R9 idle code/gs", {code_h, gs_h}, 5'b0000_0);
        check("R5 idle eo", {1'b0, eo_h}, 2'b01);
        // Pin levels for active-low variant, R7
        apply(16'h0014, 1'b1);
        check("R7 low pins code4", {code_l, gs_l, eo_l}, 6'b1011_01);
        check("R7 high pins code4", {code_h, gs_h, eo_h}, 6'b0100_10);
        // R2: lanes 2 and 4 give 4
        check("R2 lanes2+4", {2'b00, code_h}, 6'd4);
        // R8: cross-half patterns
        apply(16'h0280, 1'b1);
        check_both("R8 lanes9+7", 16'h0280, 1'b1);
        apply(16'h01FF, 1'b1);
        check_both("R8 lane8 over low", 16'h01FF, 1'b1);
        apply(16'h0080, 1'b1);
        check_both("R8 low only", 16'h0080, 1'b1);
        // R4: single lanes
        for (int k = 0; k < 16; k++) begin
            apply(16'h1 << k, 1'b1);
            check_both("R4 single lane", 16'h1 << k, 1'b1);
        end
        // R6: disabled sweep with requests present
        for (int p = 0; p < 256; p++) begin
            apply({p[7:0], p[7:0]}, 1'b0);
            check_both("R6 disabled", {p[7:0], p[7:0]}, 1'b0);
        end
        // R1 and R3: exhaustive enabled sweep
        for (int p = 0; p < 65536; p++) begin
            apply(p[15:0], 1'b1);
            check_both("R1 R3 sweep", p[15:0], 1'b1);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule